// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block decides which word of a 128-entry control store is read next in a microprogrammed control unit. It holds the control address register and a single-entry return register. Every clock it takes the sequencing fields of the microinstruction now being executed, the four-bit operation code of the machine instruction and three status flags from the datapath. From these it loads the control address register with one of four candidates:

- the current address plus one;
- the address field of the microinstruction;
- an address formed from the operation code;
- the saved return address.

The output `ctrl_addr` is the register itself and drives the control store read address directly. Whoever owns the control store feeds back the condition, branch and address fields of the word at that address. The micro-operation fields of the word do not concern this block and are not brought in. A jump or a call is gated by one status bit, chosen by the condition field. Selecting the constant-one input turns either one into an unconditional transfer.

Top module: `useq_sequencer`

## Requirements
- R1: Reset is synchronous and active high. It loads `ctrl_addr` with 64, the first word of the fetch routine, and clears the return register to 0.
- R2: When the branch field is 00 (jump) and the selected condition is true, the next `ctrl_addr` equals the address field.
- R3: When the branch field is 00 (jump) or 01 (call) and the selected condition is false, the next `ctrl_addr` is the current one plus one.
- R4: The condition field selects the gating bit. 00 selects constant true, 01 selects `dr_sign`, 10 selects `ac_sign` and 11 selects `ac_zero`. The unselected flags have no effect.
- R5: When the branch field is 01 (call) and the condition is true, the next `ctrl_addr` is the address field, and the return register takes the current `ctrl_addr` plus one.
- R6: When the branch field is 10 (return), the next `ctrl_addr` is the return register contents, whatever the condition.
- R7: When the branch field is 11 (map), the next `ctrl_addr` is a 0 followed by the four opcode bits and then two 0s, so bit 6 is 0, bits 5:2 hold the opcode and bits 1:0 are 0. This holds whatever the condition.
- R8: The return register changes only on a taken call. Jumps, untaken calls, returns and maps leave it unchanged.
- R9: The incrementer wraps modulo 128, so incrementing from 127 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cd_field | input | 2 | Condition select field of the current microinstruction |
| br_field | input | 2 | Branch kind field: 00 jump, 01 call, 10 return, 11 map |
| ad_field | input | 7 | Address field of the current microinstruction |
| opcode | input | 4 | Operation code of the machine instruction, used by map |
| dr_sign | input | 1 | Sign bit of the data register |
| ac_sign | input | 1 | Sign bit of the accumulator |
| ac_zero | input | 1 | Accumulator-is-zero flag |
| ctrl_addr | output | 7 | Control address register, read address of the control store |

## Verification
The bench sets each flag on its own against the other condition codes. A decoder that indexes the flags wrongly would jump when it should fall through, or fall through when it should jump.

It issues an untaken call between a taken call and its return. A design that writes the return register on every call would then come back to the wrong address. It also runs a return whose condition selects a false flag, which a design that gates returns would turn into an increment. The map case uses the opcode values 1111 and 0101, so a shifted or misplaced field shows up as a wrong address.

The bench steps from 127 to check the wrap. It also issues a call from address 0 and returns, then resets in mid-run and issues a return, which catches a return register that reset does not clear.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UADDR_W    = 7;
    localparam int OPC_W      = 4;
    localparam int N_STATUS   = 3;
    localparam int SEL_W      = 2;
    localparam int START_ADDR = 64;

    typedef enum logic [SEL_W-1:0] {
        COND_ONE     = 2'b00,
        COND_DR_SIGN = 2'b01,
        COND_AC_SIGN = 2'b10,
        COND_AC_ZERO = 2'b11
    } cond_sel_e;

    typedef enum logic [SEL_W-1:0] {
        BR_JUMP   = 2'b00,
        BR_CALL   = 2'b01,
        BR_RETURN = 2'b10,
        BR_MAP    = 2'b11
    } br_kind_e;

    typedef struct packed {
        cond_sel_e              cond;
        br_kind_e               kind;
        logic [UADDR_W-1:0]     target;
    } seq_fields_t;

    function automatic logic [UADDR_W-1:0] addr_plus_one(input logic [UADDR_W-1:0] a);
        return a + UADDR_W'(1);
    endfunction

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
#(
    parameter int NUM_FLAGS = N_STATUS
) (
    input  cond_sel_e              sel,
    input  logic [NUM_FLAGS-1:0]   flags,
    output logic                   taken
);
    localparam int N_IN = NUM_FLAGS + 1;

    logic [N_IN-1:0] cand;

    // input 0 is tied high so that code 00 makes any transfer unconditional
    assign cand[0] = 1'b1;

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            assign cand[i+1] = flags[i];
        end
    endgenerate

    assign taken = cand[sel];

    always_comb begin
        if (sel == COND_ONE) begin
            assert_one_true_R4: assert (taken === 1'b1 || $isunknown(sel));
        end
    end
endmodule

// File: rtl/useq_map.sv
module useq_map
    import useq_pkg::*;
#(
    parameter int ADDR_W = UADDR_W,
    parameter int OPW    = OPC_W,
    parameter int LO_PAD = 2
) (
    input  logic [OPW-1:0]    opc,
    output logic [ADDR_W-1:0] map_addr
);
    localparam int HI_PAD = ADDR_W - OPW - LO_PAD;

    generate
        if (HI_PAD > 0) begin : g_hi
            assign map_addr = {{HI_PAD{1'b0}}, opc, {LO_PAD{1'b0}}};
        end else begin : g_flush
            assign map_addr = {opc, {LO_PAD{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/useq_addr_regs.sv
module useq_addr_regs
    import useq_pkg::*;
#(
    parameter int ADDR_W = UADDR_W,
    parameter int START  = START_ADDR
) (
    input  logic               clk,
    input  logic               rst,
    input  br_kind_e           kind,
    input  logic               taken,
    input  logic [ADDR_W-1:0]  target,
    input  logic [ADDR_W-1:0]  map_addr,
    output logic [ADDR_W-1:0]  car
);
    logic [ADDR_W-1:0] sbr;
    logic [ADDR_W-1:0] incr;
    logic [ADDR_W-1:0] nxt;
    logic              link_we;

    assign incr    = car + ADDR_W'(1);
    assign link_we = (kind == BR_CALL) && taken;

    always_comb begin
        unique case (kind)
            BR_JUMP,
            BR_CALL:   nxt = taken ? target : incr;
            BR_RETURN: nxt = sbr;
            BR_MAP:    nxt = map_addr;
            default:   nxt = incr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            car <= ADDR_W'(START);
            sbr <= '0;
        end else begin
            car <= nxt;
            if (link_we) begin
                sbr <= incr;
            end
        end
    end

    assert_jump_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (kind == BR_JUMP && taken) |=> car == $past(target));

    assert_fall_through_R3: assert property (@(posedge clk) disable iff (rst)
        ((kind == BR_JUMP || kind == BR_CALL) && !taken) |=> car == $past(car) + ADDR_W'(1));

    assert_call_link_R5: assert property (@(posedge clk) disable iff (rst)
        (kind == BR_CALL && taken) |=> (sbr == $past(car) + ADDR_W'(1)) && (car == $past(target)));

    assert_return_R6: assert property (@(posedge clk) disable iff (rst)
        (kind == BR_RETURN) |=> car == $past(sbr));

    assert_map_R7: assert property (@(posedge clk) disable iff (rst)
        (kind == BR_MAP) |=> car == $past(map_addr));

    assert_link_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(kind == BR_CALL && taken) |=> $stable(sbr));
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int START = START_ADDR
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   cd_field,
    input  logic [SEL_W-1:0]   br_field,
    input  logic [UADDR_W-1:0] ad_field,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               dr_sign,
    input  logic               ac_sign,
    input  logic               ac_zero,
    output logic [UADDR_W-1:0] ctrl_addr
);
    seq_fields_t         fld;
    logic                taken;
    logic [UADDR_W-1:0]  map_addr;
    logic [N_STATUS-1:0] flags;

    assign fld.cond   = cond_sel_e'(cd_field);
    assign fld.kind   = br_kind_e'(br_field);
    assign fld.target = ad_field;

    // flag order matches the condition codes 01, 10, 11
    assign flags = {ac_zero, ac_sign, dr_sign};

    useq_cond_mux #(.NUM_FLAGS(N_STATUS)) u_cond (
        .sel   (fld.cond),
        .flags (flags),
        .taken (taken)
    );

    useq_map #(.ADDR_W(UADDR_W), .OPW(OPC_W), .LO_PAD(2)) u_map (
        .opc      (opcode),
        .map_addr (map_addr)
    );

    useq_addr_regs #(.ADDR_W(UADDR_W), .START(START)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .kind     (fld.kind),
        .taken    (taken),
        .target   (fld.target),
        .map_addr (map_addr),
        .car      (ctrl_addr)
    );

    assert_reset_start_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ctrl_addr == UADDR_W'(START));

    assert_map_shape_R7: assert property (@(posedge clk) disable iff (rst)
        (br_field == 2'b11) |=> (ctrl_addr[1:0] == 2'b00) && !ctrl_addr[UADDR_W-1]
                                && (ctrl_addr[5:2] == $past(opcode)));
endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cd_field = '0;
    logic [1:0] br_field = '0;
    logic [6:0] ad_field = '0;
    logic [3:0] opcode = '0;
    logic       dr_sign = 1'b0;
    logic       ac_sign = 1'b0;
    logic       ac_zero = 1'b0;
    logic [6:0] ctrl_addr;

    int checks = 0;
    int errors = 0;

    logic [6:0] exp_q[$];
    string      tag_q[$];
    logic [6:0] m_car = 7'd64;
    logic [6:0] m_sbr = 7'd0;

    always #5 clk = ~clk;

    useq_sequencer u_useq_sequencer (
        .clk       (clk),
        .rst       (rst),
        .cd_field  (cd_field),
        .br_field  (br_field),
        .ad_field  (ad_field),
        .opcode    (opcode),
        .dr_sign   (dr_sign),
        .ac_sign   (ac_sign),
        .ac_zero   (ac_zero),
        .ctrl_addr (ctrl_addr)
    );

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ctrl_addr actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: applies one microinstruction and queues the expected next address
    task automatic drive(input logic [1:0] cd, input logic [1:0] br, input logic [6:0] ad,
                         input logic [3:0] opc, input logic dr, input logic as_, input logic az,
                         input string tag);
        logic       c;
        logic [6:0] nx;
        @(negedge clk);
        rst      = 1'b0;
        cd_field = cd;
        br_field = br;
        ad_field = ad;
        opcode   = opc;
        dr_sign  = dr;
        ac_sign  = as_;
        ac_zero  = az;
        case (cd)
            2'b00:   c = 1'b1;
            2'b01:   c = dr;
            2'b10:   c = as_;
            default: c = az;
        endcase
        case (br)
            2'b00: nx = c ? ad : m_car + 7'd1;
            2'b01: begin
                if (c) begin
                    m_sbr = m_car + 7'd1;
                    nx = ad;
                end else begin
                    nx = m_car + 7'd1;
                end
            end
            2'b10:   nx = m_sbr;
            default: nx = {1'b0, opc, 2'b00};
        endcase
        m_car = nx;
        exp_q.push_back(nx);
        tag_q.push_back(tag);
    endtask

    // monitor: compares each result shortly after the edge that produced it
    always @(posedge clk) begin
        logic [6:0] e;
        string      t;
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, ctrl_addr, e);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset address", ctrl_addr, 7'd64);
        m_car = 7'd64;
        m_sbr = 7'd0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset address", ctrl_addr, 7'd64);

        drive(2'b01, 2'b00, 7'd9,  4'h0, 1'b0, 1'b1, 1'b1, "R3 jump untaken on dr_sign=0");
        drive(2'b00, 2'b00, 7'd10, 4'h0, 1'b0, 1'b0, 1'b0, "R2 jump always");
        drive(2'b01, 2'b00, 7'd20, 4'h0, 1'b1, 1'b0, 1'b0, "R4 cd=01 dr_sign");
        drive(2'b10, 2'b00, 7'd30, 4'h0, 1'b0, 1'b1, 1'b0, "R4 cd=10 ac_sign");
        drive(2'b10, 2'b00, 7'd99, 4'h0, 1'b1, 1'b0, 1'b1, "R4 cd=10 ignores other flags");
        drive(2'b11, 2'b00, 7'd40, 4'h0, 1'b0, 1'b0, 1'b1, "R4 cd=11 ac_zero");
        drive(2'b00, 2'b01, 7'd100, 4'h0, 1'b0, 1'b0, 1'b0, "R5 call taken");
        drive(2'b11, 2'b01, 7'd7,  4'h0, 1'b1, 1'b1, 1'b0, "R3 call untaken");
        drive(2'b00, 2'b00, 7'd5,  4'h0, 1'b0, 1'b0, 1'b0, "R2 jump to 5");
        drive(2'b11, 2'b10, 7'd77, 4'h0, 1'b0, 1'b0, 1'b0, "R6 R8 return with false cond");
        drive(2'b01, 2'b11, 7'd3,  4'hF, 1'b0, 1'b0, 1'b0, "R7 map opcode 1111");
        drive(2'b00, 2'b11, 7'd3,  4'h5, 1'b0, 1'b0, 1'b0, "R7 map opcode 0101");
        drive(2'b00, 2'b00, 7'd127, 4'h0, 1'b0, 1'b0, 1'b0, "R2 jump to 127");
        drive(2'b10, 2'b00, 7'd50, 4'h0, 1'b0, 1'b0, 1'b0, "R9 wrap 127 to 0");
        drive(2'b00, 2'b01, 7'd126, 4'h0, 1'b0, 1'b0, 1'b0, "R5 call from 0");
        drive(2'b01, 2'b00, 7'd12, 4'h0, 1'b0, 1'b0, 1'b0, "R3 increment to 127");
        drive(2'b00, 2'b10, 7'd12, 4'h0, 1'b0, 1'b0, 1'b0, "R6 return to 1");
        drive(2'b00, 2'b11, 7'd0,  4'h9, 1'b0, 1'b0, 1'b0, "R7 R8 map then keep link");
        drive(2'b00, 2'b10, 7'd0,  4'h0, 1'b0, 1'b0, 1'b0, "R8 link unchanged by map");

        do_reset();
        drive(2'b00, 2'b10, 7'd33, 4'h0, 1'b0, 1'b0, 1'b0, "R1 return register cleared");

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule